// File: doc/BRIEF.md
# Table-Driven Configuration Sequencer

This block steps through a stored program of configuration steps without help from a host processor. Every executed step produces one 67-bit configuration word for a datapath. A host fills the stores through a write port, then issues a start command. After that the sequencer works through the program on its own, one entry per clock. It takes jumps, conditional jumps, counted loops and waits on a datapath status bit, and it stops at a halt entry.

Storage is split to keep it small. A 128-entry program store holds 8-bit entries. Each entry carries a 3-bit operation code and a 5-bit index into a per-step word store of 32 words by 32 bits. A 32-bit constant word is held for the whole run. Its low bits also give the run unit a jump target and a loop count.

There are two banks, each with one step store and one constant word. Exactly one bank is active. The host may rewrite the other bank during a run. It switches banks only while the sequencer is idle.

The control state machine has three states:
- IDLE: not running.
- RUN: executes one entry per clock.
- PAUSE: executes one entry per step pulse.

Its transitions are:
- IDLE to RUN, on start with single-step mode off.
- IDLE to PAUSE, on start with single-step mode on.
- RUN to IDLE and PAUSE to IDLE, on executing a halt entry.

Top module: `cfg_sequencer`

## Requirements
- R1: After reset the block is in IDLE, `busy`=0, `cfg_valid`=0, `cfg_vec`=0 and `active_bank`=0.
- R2: The configuration word has this layout: bits [66:64] hold the operation code of the entry, bits [63:32] the step word it selects, and bits [31:0] the constant word of the active bank. A start command is taken at clock edge E. The entry at the start address is then executed at edge E+1, and its word appears with `cfg_valid`=1 just after that edge. Each later entry follows one clock apart.
- R3: A program entry has the operation in bits [7:5] and the step index in bits [4:0]. Codes 0, 1 and 2 are plain steps: each emits a word and advances to the next address.
- R4: Code 3 (jump) emits no word and continues at the address in constant-word bits [6:0].
- R5: Code 4 (conditional jump) emits no word. It goes to the constant-word target if `dp_status` is 1 when it executes, and to the next address otherwise.
- R6: Code 5 (loop) emits no word. If the loop counter is nonzero, it decrements the counter and goes to the target. If the counter is zero, it reloads the counter from constant-word bits [15:8] and falls through. The counter is also loaded from those bits at start, so the loop body runs count+1 times.
- R7: Code 6 (halt) emits no word and returns the block to IDLE, so `busy` falls.
- R8: Code 7 (wait) emits no word. It stays on the same entry until it executes with `dp_status`=1, and then advances.
- R9: When started with `single`=1, the block enters PAUSE. Each `step` pulse then executes exactly one entry, and no entry executes without a pulse.
- R10: A `swap` pulse toggles `active_bank` only in IDLE, and only when `go` is not asserted in the same cycle. It is ignored while busy.
- R11: Step-word and constant-word writes aimed at the active bank are dropped while busy. Writes to the inactive bank always take effect. Write kind is selected by `wr_kind`: 0 is a program entry, 1 is a step word, 2 is the constant word, and 3 is ignored.
- R12: Program entries may be rewritten during a run and take effect when reached. The program address wraps from 127 to 0.
- R13: `busy` rises only on an accepted `go`. A `go` issued while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start command pulse |
| go_pc | input | 7 | Program address to start from |
| single | input | 1 | Start in single-step mode |
| step | input | 1 | Execute one entry while in PAUSE |
| swap | input | 1 | Request to toggle the active bank |
| dp_status | input | 1 | Datapath condition for conditional jump and wait |
| wr_en | input | 1 | Store write strobe |
| wr_kind | input | 2 | Write target: 0 program, 1 step word, 2 constant, 3 none |
| wr_bank | input | 1 | Bank for step and constant writes |
| wr_addr | input | 7 | Program address, or step index in bits [4:0] |
| wr_data | input | 32 | Write data (program entry in bits [7:0]) |
| busy | output | 1 | High in RUN and PAUSE |
| active_bank | output | 1 | Bank currently feeding the configuration word |
| cfg_valid | output | 1 | A configuration word is presented this cycle |
| cfg_vec | output | 67 | Configuration word |

## Verification
Several properties are checked on every cycle:
- The active bank never changes while busy.
- `busy` only rises after a start command.
- A halt always drops `busy`.
- A wait with low status holds the program address.
- An exhausted loop reloads its counter from the constant word.
- A protected constant word keeps its value.
- A valid word is always preceded by a busy cycle.

The exact word contents, loop trip counts, jump and conditional-jump paths, single-step pacing, address wrap and the effect of mid-run rewrites are shown only by the bench's scenarios. The scoreboard matches every emitted word, in order, against words predicted from the programmed stores.

// File: rtl/cfg_seq_pkg.sv
`timescale 1ns/1ps
package cfg_seq_pkg;
    typedef enum logic [2:0] {
        OP_STEP0 = 3'd0,
        OP_STEP1 = 3'd1,
        OP_STEP2 = 3'd2,
        OP_JUMP  = 3'd3,
        OP_JIF   = 3'd4,
        OP_LOOP  = 3'd5,
        OP_HALT  = 3'd6,
        OP_WAIT  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        WK_PROG  = 2'd0,
        WK_STEP  = 2'd1,
        WK_CONST = 2'd2,
        WK_NONE  = 2'd3
    } wkind_e;

    localparam int OP_W = 3;
endpackage

// File: rtl/prog_store.sv
`timescale 1ns/1ps
module prog_store #(
    parameter int AW = 7,
    parameter int EW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [EW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [EW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [EW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/bank_store.sv
`timescale 1ns/1ps
module bank_store #(
    parameter int SW = 5,
    parameter int WW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_step,
    input  logic          wr_const,
    input  logic          wr_bank,
    input  logic [SW-1:0] wr_idx,
    input  logic [WW-1:0] wr_data,
    input  logic          busy,
    input  logic          act_bank,
    input  logic [SW-1:0] rd_idx,
    output logic [WW-1:0] step_word,
    output logic [WW-1:0] const_word
);
    localparam int NBANK = 2;
    localparam int DEPTH = 1 << SW;

    logic [WW-1:0] step_rd [NBANK];
    logic [WW-1:0] const_q [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [WW-1:0] mem [DEPTH];
        logic          open_w;

        assign open_w = !(busy && (act_bank == 1'(b)));

        always_ff @(posedge clk) begin
            if (wr_step && (wr_bank == 1'(b)) && open_w) begin
                mem[wr_idx] <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                const_q[b] <= '0;
            end else if (wr_const && (wr_bank == 1'(b)) && open_w) begin
                const_q[b] <= wr_data;
            end
        end

        assign step_rd[b] = mem[rd_idx];

        // R11: active constant word is frozen while a run is in progress
        p_const_protect_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_const && wr_bank == 1'(b) && busy && act_bank == 1'(b))
                |=> $stable(const_q[b]));
    end

    assign step_word  = step_rd[act_bank];
    assign const_word = const_q[act_bank];
endmodule

// File: rtl/run_unit.sv
`timescale 1ns/1ps
module run_unit
    import cfg_seq_pkg::*;
#(
    parameter int AW   = 7,
    parameter int CNTW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [AW-1:0]   go_pc,
    input  logic            single,
    input  logic            step,
    input  logic            swap,
    input  logic            status,
    input  logic [OP_W-1:0] op_bits,
    input  logic [AW-1:0]   target,
    input  logic [CNTW-1:0] reload,
    output logic [AW-1:0]   pc,
    output logic            busy,
    output logic            act_bank,
    output logic            emit
);
    state_e          state_q, state_d;
    logic [AW-1:0]   pc_q, pc_d;
    logic [CNTW-1:0] cnt_q, cnt_d;
    logic            bank_q, bank_d;
    logic            exec;
    op_e             op;

    assign op   = op_e'(op_bits);
    assign exec = (state_q == ST_RUN) || ((state_q == ST_PAUSE) && step);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            cnt_q   <= '0;
            bank_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            cnt_q   <= cnt_d;
            bank_q  <= bank_d;
        end
    end

    // next-state and sequencing
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        cnt_d   = cnt_q;
        bank_d  = bank_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    state_d = single ? ST_PAUSE : ST_RUN;
                    pc_d    = go_pc;
                    cnt_d   = reload;
                end else if (swap) begin
                    bank_d = ~bank_q;
                end
            end
            ST_RUN, ST_PAUSE: begin
                if (exec) begin
                    unique case (op)
                        OP_STEP0, OP_STEP1, OP_STEP2: pc_d = pc_q + AW'(1);
                        OP_JUMP: pc_d = target;
                        OP_JIF:  pc_d = status ? target : pc_q + AW'(1);
                        OP_LOOP: begin
                            if (cnt_q != '0) begin
                                cnt_d = cnt_q - CNTW'(1);
                                pc_d  = target;
                            end else begin
                                cnt_d = reload;
                                pc_d  = pc_q + AW'(1);
                            end
                        end
                        OP_HALT: state_d = ST_IDLE;
                        OP_WAIT: pc_d = status ? pc_q + AW'(1) : pc_q;
                    endcase
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pc       = pc_q;
        busy     = (state_q != ST_IDLE);
        act_bank = bank_q;
        emit     = exec && ((op == OP_STEP0) || (op == OP_STEP1) || (op == OP_STEP2));
    end

    p_bank_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(bank_q));

    p_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go));

    p_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_HALT) |=> !busy);

    p_wait_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_WAIT && !status) |=> $stable(pc_q));

    p_loop_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_LOOP && cnt_q == '0) |=> (cnt_q == $past(reload)));
endmodule

// File: rtl/cfg_sequencer.sv
`timescale 1ns/1ps
module cfg_sequencer
    import cfg_seq_pkg::*;
#(
    parameter int AW      = 7,
    parameter int SW      = 5,
    parameter int WW      = 32,
    parameter int CNT_LSB = 8,
    parameter int CNTW    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   go,
    input  logic [AW-1:0]          go_pc,
    input  logic                   single,
    input  logic                   step,
    input  logic                   swap,
    input  logic                   dp_status,
    input  logic                   wr_en,
    input  logic [1:0]             wr_kind,
    input  logic                   wr_bank,
    input  logic [AW-1:0]          wr_addr,
    input  logic [WW-1:0]          wr_data,
    output logic                   busy,
    output logic                   active_bank,
    output logic                   cfg_valid,
    output logic [OP_W+2*WW-1:0]   cfg_vec
);
    localparam int EW   = OP_W + SW;
    localparam int VECW = OP_W + 2 * WW;

    logic [EW-1:0] entry;
    logic [AW-1:0] pc;
    logic [WW-1:0] step_word, const_word;
    logic          emit;
    logic          wr_prog, wr_step, wr_const;

    assign wr_prog  = wr_en && (wkind_e'(wr_kind) == WK_PROG);
    assign wr_step  = wr_en && (wkind_e'(wr_kind) == WK_STEP);
    assign wr_const = wr_en && (wkind_e'(wr_kind) == WK_CONST);

    prog_store #(.AW(AW), .EW(EW)) u_prog (
        .clk   (clk),
        .we    (wr_prog),
        .waddr (wr_addr),
        .wdata (wr_data[EW-1:0]),
        .raddr (pc),
        .rdata (entry)
    );

    bank_store #(.SW(SW), .WW(WW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_step    (wr_step),
        .wr_const   (wr_const),
        .wr_bank    (wr_bank),
        .wr_idx     (wr_addr[SW-1:0]),
        .wr_data    (wr_data),
        .busy       (busy),
        .act_bank   (active_bank),
        .rd_idx     (entry[SW-1:0]),
        .step_word  (step_word),
        .const_word (const_word)
    );

    run_unit #(.AW(AW), .CNTW(CNTW)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .go_pc    (go_pc),
        .single   (single),
        .step     (step),
        .swap     (swap),
        .status   (dp_status),
        .op_bits  (entry[EW-1 -: OP_W]),
        .target   (const_word[AW-1:0]),
        .reload   (const_word[CNT_LSB +: CNTW]),
        .pc       (pc),
        .busy     (busy),
        .act_bank (active_bank),
        .emit     (emit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_valid <= 1'b0;
            cfg_vec   <= '0;
        end else begin
            cfg_valid <= emit;
            if (emit) begin
                cfg_vec <= VECW'({entry[EW-1 -: OP_W], step_word, const_word});
            end
        end
    end

    p_valid_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> $past(busy));
endmodule

// File: tb/sim_cfg_sequencer.sv
`timescale 1ns/1ps
module sim_cfg_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0, single = 1'b0, step = 1'b0, swap = 1'b0, dp_status = 1'b0;
    logic [6:0]  go_pc = '0;
    logic        wr_en = 1'b0, wr_bank = 1'b0;
    logic [1:0]  wr_kind = 2'd3;
    logic [6:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        busy, active_bank, cfg_valid;
    logic [66:0] cfg_vec;

    int nchk = 0;
    int nbad = 0;

    typedef struct {
        logic [66:0] vec;
        string       tag;
    } exp_t;
    exp_t q[$];
    exp_t mon_e;

    localparam logic [31:0] C0 = 32'h1234_0205; // target 5, loop count 2
    localparam logic [31:0] C1 = 32'h5500_0110;

    always #4 clk = ~clk;

    cfg_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .go(go), .go_pc(go_pc), .single(single),
        .step(step), .swap(swap), .dp_status(dp_status), .wr_en(wr_en),
        .wr_kind(wr_kind), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .active_bank(active_bank), .cfg_valid(cfg_valid), .cfg_vec(cfg_vec)
    );

    function automatic logic [66:0] mk(input logic [2:0] d, input logic [31:0] s,
                                       input logic [31:0] c);
        return {d, s, c};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [66:0] act,
                       input logic [66:0] expv);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic expect_vec(input logic [66:0] v, input string tag);
        exp_t e;
        e.vec = v;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wr(input logic [1:0] k, input logic b, input logic [6:0] a,
                      input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = k; wr_bank = b; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_kind = 2'd3;
    endtask

    task automatic pulse_go(input logic [6:0] pc, input logic sgl);
        @(negedge clk);
        go = 1'b1; go_pc = pc; single = sgl;
        @(negedge clk);
        go = 1'b0; single = 1'b0;
    endtask

    task automatic pulse_step();
        @(negedge clk);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic pulse_swap();
        @(negedge clk);
        swap = 1'b1;
        @(negedge clk);
        swap = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (busy && n < 300) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        chk(busy == 1'b0, tag, 67'(busy), 67'(0));
        chk(q.size() == 0, "R2", 67'(q.size()), 67'(0));
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && cfg_valid) begin
            nchk++;
            if (q.size() == 0) begin
                nbad++;
                $display("FAIL R2 unexpected word actual=%h expected=none", cfg_vec);
            end else begin
                mon_e = q.pop_front();
                if (cfg_vec !== mon_e.vec) begin
                    nbad++;
                    $display("FAIL %s actual=%h expected=%h", mon_e.tag, cfg_vec, mon_e.vec);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", 67'(busy), 67'(0));
        chk(cfg_valid == 1'b0, "R1", 67'(cfg_valid), 67'(0));
        chk(cfg_vec == '0, "R1", cfg_vec, 67'(0));
        chk(active_bank == 1'b0, "R1", 67'(active_bank), 67'(0));

        for (int k = 0; k < 8; k++) begin
            wr(2'd1, 1'b0, 7'(k), 32'hA000_0000 | 32'(k));
            wr(2'd1, 1'b1, 7'(k), 32'hB100_0000 | 32'(k));
        end
        wr(2'd2, 1'b0, 7'd0, C0);
        wr(2'd0, 1'b0, 7'd0, 32'h01);
        wr(2'd0, 1'b0, 7'd1, 32'h22);
        wr(2'd0, 1'b0, 7'd2, 32'h43);
        wr(2'd0, 1'b0, 7'd3, 32'hC0);
        wr(2'd0, 1'b0, 7'd4, 32'h60);
        wr(2'd0, 1'b0, 7'd5, 32'h04);
        wr(2'd0, 1'b0, 7'd6, 32'hA0);
        wr(2'd0, 1'b0, 7'd7, 32'hC0);
        wr(2'd0, 1'b0, 7'd8, 32'h80);
        wr(2'd0, 1'b0, 7'd9, 32'h26);
        wr(2'd0, 1'b0, 7'd10, 32'hC0);
        wr(2'd0, 1'b0, 7'd11, 32'hE0);
        wr(2'd0, 1'b0, 7'd12, 32'h47);
        wr(2'd0, 1'b0, 7'd13, 32'hC0);
        wr(2'd0, 1'b0, 7'd20, 32'hE0);
        wr(2'd0, 1'b0, 7'd21, 32'h00);
        wr(2'd0, 1'b0, 7'd22, 32'hC0);

        // R2 R3 R7: plain steps then halt
        expect_vec(mk(3'd0, 32'hA000_0001, C0), "R3");
        expect_vec(mk(3'd1, 32'hA000_0002, C0), "R2");
        expect_vec(mk(3'd2, 32'hA000_0003, C0), "R3");
        pulse_go(7'd0, 1'b0);
        chk(busy == 1'b1, "R13", 67'(busy), 67'(1));
        wait_idle("R7");

        // R4 R6: jump into a loop body run count+1 times
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < 3; i++) expect_vec(mk(3'd0, 32'hA000_0004, C0), "R6");
            pulse_go(r == 0 ? 7'd4 : 7'd5, 1'b0);
            wait_idle("R4");
        end

        // R5: conditional jump, status low then high
        expect_vec(mk(3'd1, 32'hA000_0006, C0), "R5");
        pulse_go(7'd8, 1'b0);
        wait_idle("R5");
        dp_status = 1'b1;
        for (int i = 0; i < 3; i++) expect_vec(mk(3'd0, 32'hA000_0004, C0), "R5");
        pulse_go(7'd8, 1'b0);
        wait_idle("R5");
        dp_status = 1'b0;

        // R8: wait holds until status
        pulse_go(7'd11, 1'b0);
        repeat (4) @(negedge clk);
        chk(cfg_valid == 1'b0, "R8", 67'(cfg_valid), 67'(0));
        chk(busy == 1'b1, "R8", 67'(busy), 67'(1));
        expect_vec(mk(3'd2, 32'hA000_0007, C0), "R8");
        dp_status = 1'b1;
        @(negedge clk);
        dp_status = 1'b0;
        wait_idle("R8");

        // R9: single step
        pulse_go(7'd0, 1'b1);
        repeat (3) @(negedge clk);
        chk(cfg_valid == 1'b0, "R9", 67'(cfg_valid), 67'(0));
        chk(busy == 1'b1, "R9", 67'(busy), 67'(1));
        expect_vec(mk(3'd0, 32'hA000_0001, C0), "R9");
        pulse_step();
        @(negedge clk);
        chk(cfg_valid == 1'b0, "R9", 67'(cfg_valid), 67'(0));
        expect_vec(mk(3'd1, 32'hA000_0002, C0), "R9");
        pulse_step();
        expect_vec(mk(3'd2, 32'hA000_0003, C0), "R9");
        pulse_step();
        chk(busy == 1'b1, "R9", 67'(busy), 67'(1));
        pulse_step();
        wait_idle("R9");

        // R10 R11 R13: protection and swap while busy
        pulse_go(7'd20, 1'b0);
        wr(2'd2, 1'b0, 7'd0, 32'hDEAD_0000);
        wr(2'd1, 1'b0, 7'd0, 32'hFFFF_FFFF);
        wr(2'd2, 1'b1, 7'd0, C1);
        pulse_swap();
        chk(active_bank == 1'b0, "R10", 67'(active_bank), 67'(0));
        pulse_go(7'd0, 1'b0);
        chk(busy == 1'b1, "R13", 67'(busy), 67'(1));
        expect_vec(mk(3'd0, 32'hA000_0000, C0), "R11");
        dp_status = 1'b1;
        @(negedge clk);
        dp_status = 1'b0;
        wait_idle("R13");
        pulse_swap();
        chk(active_bank == 1'b1, "R10", 67'(active_bank), 67'(1));
        expect_vec(mk(3'd0, 32'hB100_0000, C1), "R11");
        pulse_go(7'd21, 1'b0);
        wait_idle("R11");

        // R12: rewrite during run, wrap 127 -> 0
        wr(2'd0, 1'b0, 7'd125, 32'hE0);
        wr(2'd0, 1'b0, 7'd126, 32'h01);
        wr(2'd0, 1'b0, 7'd127, 32'h00);
        wr(2'd0, 1'b0, 7'd0, 32'hC0);
        pulse_go(7'd125, 1'b0);
        wr(2'd0, 1'b0, 7'd127, 32'h22);
        expect_vec(mk(3'd0, 32'hB100_0001, C1), "R12");
        expect_vec(mk(3'd1, 32'hB100_0002, C1), "R12");
        dp_status = 1'b1;
        @(negedge clk);
        dp_status = 1'b0;
        wait_idle("R12");

        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule